// File: doc/BRIEF.md
# Buffered UART with Selectable Receive Threshold and Multidrop Addressing

This block is a full-duplex asynchronous serial port for a host that reads and writes it through a plain strobe interface. Each direction has a 16-entry queue. Characters the host writes are sent on the serial output in order. Characters that arrive on the serial input are queued for the host to read. The interrupt output rises once the receive queue reaches a threshold the host picks from four fixed levels.

Line timing comes from a baud tick, and each serial bit lasts 16 ticks. The tick is produced by an integer prescaler. A fractional stage stretches some prescaler periods by one clock, which lets standard rates be reached from clock frequencies that are not convenient multiples of them.

A 9-bit mode serves multidrop buses, where the ninth bit marks a character as an address. With hardware filtering enabled, the block matches address characters against its own station number. It then keeps only the data characters sent to that station. With filtering disabled, every 9-bit character is handed to the host with its ninth bit, and the host does the address handling. A clear-to-send input pauses transmission at character boundaries.

Top module: `uart_core`

## Requirements
- R1: After reset, `tx_o` is high, `rx_empty_o` is 1, and `tx_full_o`, `irq_o` and `overrun_o` are 0.
- R2: A transmitted character is one low start bit, then the data bits LSB first (8 bits, or 9 when `nine_bit_i` is 1), then one high stop bit. Every bit lasts 16 baud ticks.
- R3: The baud tick period is `prescale_i` clocks (0 acts as 1). On `divadd_i` out of every `mulval_i` periods it is one clock longer. Back-to-back 10-bit characters therefore start 160·(prescale + divadd/mulval) clocks apart, within ±1 clock.
- R4: While `cts_i` is low, no new character starts. A character already on the line completes normally.
- R5: The transmit queue holds 16 characters. `tx_full_o` rises on the 16th unsent write.
- R6: The receiver confirms a start bit at its mid-point. A low pulse shorter than half a bit produces no character.
- R7: `irq_o` is 1 exactly when the receive queue holds at least the threshold chosen by `trig_sel_i`: 0→1, 1→4, 2→8, 3→14 characters.
- R8: A character that completes while the receive queue holds 16 is dropped, and `overrun_o` is set. A pulse on `stat_rd_i` clears `overrun_o`.
- R9: Received characters appear on `rd_data_o` in arrival order. In 8-bit mode bit 8 reads 0. In 9-bit mode with `auto_addr_i` low, every character is stored with its ninth bit in bit 8.
- R10: With `nine_bit_i` and `auto_addr_i` both 1, address characters (ninth bit 1) are never stored. A matching address, with bits 7:0 equal to `station_addr_i`, enables storage of the data characters (ninth bit 0) that follow. A non-matching address disables it. Storage is disabled after reset.
- R11: A character whose stop bit samples low is discarded, and the next well-formed character is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Push `wr_data_i` into the transmit queue |
| wr_data_i | input | 9 | Character to send; bit 8 is used only in 9-bit mode |
| tx_full_o | output | 1 | Transmit queue full |
| rd_en_i | input | 1 | Pop the head of the receive queue |
| rd_data_o | output | 9 | Head of the receive queue |
| rx_empty_o | output | 1 | Receive queue empty |
| stat_rd_i | input | 1 | Status read; clears the overrun flag |
| overrun_o | output | 1 | Receive overrun flag |
| prescale_i | input | 16 | Integer clocks per baud tick |
| mulval_i | input | 4 | Fractional denominator, 1..15 |
| divadd_i | input | 4 | Fractional numerator, below `mulval_i` |
| trig_sel_i | input | 2 | Receive threshold select |
| nine_bit_i | input | 1 | 9-bit character mode |
| auto_addr_i | input | 1 | Hardware address filtering in 9-bit mode |
| station_addr_i | input | 8 | Own station address |
| tx_o | output | 1 | Serial output, idle high |
| rx_i | input | 1 | Serial input, idle high |
| cts_i | input | 1 | Clear to send, active high |
| irq_o | output | 1 | Receive threshold interrupt |

## Verification
The bench builds the block with its default parameters: 16-entry queues, a 16-bit prescaler and a 4-bit fractional stage. For most tests it runs with a prescale of 1, so one bit lasts 16 clocks. At that rate, filling the receive queue to its limit and forcing an overrun takes only a few thousand cycles. The bench then resets the block with prescale 3, and again with prescale 2 plus a half-step fraction, to compare character spacing against the integer and fractional period formulas.

// File: rtl/uart_pkg.sv
package uart_pkg;
  localparam int FRAME_W = 9;

  typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_e;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

  function automatic int trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int PRE_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PRE_W-1:0]  prescale_i,
  input  logic [FRAC_W-1:0] mulval_i,
  input  logic [FRAC_W-1:0] divadd_i,
  output logic              tick_o
);
  localparam int BW = PRE_W + 1;
  localparam int AW = FRAC_W + 1;

  logic [BW-1:0] cnt_q, base, period;
  logic [AW-1:0] acc_q, acc_sum;
  logic          ext_q;

  assign base    = (prescale_i == '0) ? BW'(1) : {1'b0, prescale_i};
  assign period  = base + {{PRE_W{1'b0}}, ext_q};
  assign tick_o  = (cnt_q == period - 1'b1);
  assign acc_sum = acc_q + {1'b0, divadd_i};

  // the stretch decision is made per period by a remainder accumulator
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      acc_q <= '0;
      ext_q <= 1'b0;
    end else if (tick_o) begin
      cnt_q <= '0;
      if (acc_sum >= {1'b0, mulval_i}) begin
        acc_q <= acc_sum - {1'b0, mulval_i};
        ext_q <= 1'b1;
      end else begin
        acc_q <= acc_sum;
        ext_q <= 1'b0;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3
  tick_space_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && base != BW'(1)) |=> !tick_o);
endmodule

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q, wptr_nx, rptr_nx;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign count_o = cnt_q;
  assign data_o  = mem_q[rptr_q];

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wptr_nx = wptr_q + 1'b1;
      assign rptr_nx = rptr_q + 1'b1;
    end else begin : g_wrap
      assign wptr_nx = (wptr_q == PTR_W'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      assign rptr_nx = (rptr_q == PTR_W'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= wptr_nx;
      if (do_pop)  rptr_q <= rptr_nx;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R5
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/uart_tx.sv
module uart_tx import uart_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               nine_bit_i,
  input  logic               cts_i,
  input  logic               empty_i,
  input  logic [FRAME_W-1:0] data_i,
  output logic               pop_o,
  output logic               tx_o
);
  tx_state_e          state_q;
  logic [3:0]         sub_q, bit_q, last_bit;
  logic [FRAME_W-1:0] shreg_q;

  assign last_bit = nine_bit_i ? 4'd8 : 4'd7;
  // a new frame may start from idle or straight out of a finished stop bit
  assign pop_o = tick_i && !empty_i && cts_i &&
                 (state_q == TX_IDLE || (state_q == TX_STOP && sub_q == 4'd15));

  always_comb begin
    case (state_q)
      TX_START: tx_o = 1'b0;
      TX_DATA:  tx_o = shreg_q[0];
      default:  tx_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      sub_q   <= '0;
      bit_q   <= '0;
      shreg_q <= '0;
    end else if (pop_o) begin
      state_q <= TX_START;
      sub_q   <= '0;
      shreg_q <= data_i;
    end else if (tick_i) begin
      case (state_q)
        TX_START: begin
          sub_q <= sub_q + 1'b1;
          if (sub_q == 4'd15) begin
            state_q <= TX_DATA;
            bit_q   <= '0;
          end
        end
        TX_DATA: begin
          sub_q <= sub_q + 1'b1;
          if (sub_q == 4'd15) begin
            shreg_q <= shreg_q >> 1;
            if (bit_q == last_bit) state_q <= TX_STOP;
            else                   bit_q   <= bit_q + 1'b1;
          end
        end
        TX_STOP: begin
          sub_q <= sub_q + 1'b1;
          if (sub_q == 4'd15) state_q <= TX_IDLE;
        end
        default: sub_q <= '0;
      endcase
    end
  end

  // R2
  tx_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |=> (state_q == TX_START) && !tx_o);
  // R4
  cts_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cts_i && state_q == TX_IDLE) |=> state_q == TX_IDLE);
endmodule

// File: rtl/uart_rx.sv
module uart_rx import uart_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               rx_i,
  input  logic               nine_bit_i,
  output logic               done_o,
  output logic [FRAME_W-1:0] data_o
);
  rx_state_e          state_q;
  logic [3:0]         sub_q, bit_q, last_bit;
  logic [FRAME_W-1:0] shreg_q;
  logic               ferr_q;

  assign last_bit = nine_bit_i ? 4'd8 : 4'd7;
  assign data_o   = nine_bit_i ? shreg_q : {1'b0, shreg_q[FRAME_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      sub_q   <= '0;
      bit_q   <= '0;
      shreg_q <= '0;
      ferr_q  <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        case (state_q)
          RX_IDLE: if (!rx_i) begin
            state_q <= RX_START;
            sub_q   <= '0;
          end
          RX_START: begin
            sub_q <= sub_q + 1'b1;
            if (sub_q == 4'd7) begin
              sub_q   <= '0;
              bit_q   <= '0;
              state_q <= rx_i ? RX_IDLE : RX_DATA;  // glitch rejected at mid-start
            end
          end
          RX_DATA: begin
            sub_q <= sub_q + 1'b1;
            if (sub_q == 4'd15) begin
              shreg_q <= {rx_i, shreg_q[FRAME_W-1:1]};
              if (bit_q == last_bit) state_q <= RX_STOP;
              else                   bit_q   <= bit_q + 1'b1;
            end
          end
          default: begin
            if (sub_q != 4'd15) sub_q <= sub_q + 1'b1;
            else if (rx_i) begin
              state_q <= RX_IDLE;
              done_o  <= !ferr_q;
              ferr_q  <= 1'b0;
            end else begin
              ferr_q <= 1'b1;  // hold until the line returns high
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_core.sv
module uart_core import uart_pkg::*; #(
  parameter int FIFO_DEPTH = 16,
  parameter int PRE_W      = 16,
  parameter int FRAC_W     = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [FRAME_W-1:0] wr_data_i,
  output logic               tx_full_o,
  input  logic               rd_en_i,
  output logic [FRAME_W-1:0] rd_data_o,
  output logic               rx_empty_o,
  input  logic               stat_rd_i,
  output logic               overrun_o,
  input  logic [PRE_W-1:0]   prescale_i,
  input  logic [FRAC_W-1:0]  mulval_i,
  input  logic [FRAC_W-1:0]  divadd_i,
  input  logic [1:0]         trig_sel_i,
  input  logic               nine_bit_i,
  input  logic               auto_addr_i,
  input  logic [7:0]         station_addr_i,
  output logic               tx_o,
  input  logic               rx_i,
  input  logic               cts_i,
  output logic               irq_o
);
  localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

  logic [1:0]         rx_sync_q, cts_sync_q;
  logic               tick, tx_pop, tx_empty, rx_done, rx_full;
  logic               auto_mode, accept_q, rx_store;
  logic [FRAME_W-1:0] tx_head, rx_data;
  logic [CNT_W-1:0]   tx_count, rx_count;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sync_q  <= 2'b11;
      cts_sync_q <= 2'b00;
    end else begin
      rx_sync_q  <= {rx_sync_q[0], rx_i};
      cts_sync_q <= {cts_sync_q[0], cts_i};
    end
  end

  uart_baud_gen #(.PRE_W(PRE_W), .FRAC_W(FRAC_W)) u_baud (
    .clk_i, .rst_ni, .prescale_i, .mulval_i, .divadd_i, .tick_o(tick));

  uart_fifo #(.WIDTH(FRAME_W), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_tx_fifo (
    .clk_i, .rst_ni, .push_i(wr_en_i), .data_i(wr_data_i), .pop_i(tx_pop),
    .data_o(tx_head), .empty_o(tx_empty), .full_o(tx_full_o), .count_o(tx_count));

  uart_tx u_tx (
    .clk_i, .rst_ni, .tick_i(tick), .nine_bit_i, .cts_i(cts_sync_q[1]),
    .empty_i(tx_empty), .data_i(tx_head), .pop_o(tx_pop), .tx_o);

  uart_rx u_rx (
    .clk_i, .rst_ni, .tick_i(tick), .rx_i(rx_sync_q[1]), .nine_bit_i,
    .done_o(rx_done), .data_o(rx_data));

  // station filter: address frames steer acceptance, never enter the queue
  assign auto_mode = nine_bit_i && auto_addr_i;
  assign rx_store  = rx_done && (!auto_mode || (!rx_data[8] && accept_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_q  <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      if (rx_done && auto_mode && rx_data[8])
        accept_q <= (rx_data[7:0] == station_addr_i);
      if (rx_store && rx_full) overrun_o <= 1'b1;
      else if (stat_rd_i)      overrun_o <= 1'b0;
    end
  end

  uart_fifo #(.WIDTH(FRAME_W), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_rx_fifo (
    .clk_i, .rst_ni, .push_i(rx_store), .data_i(rx_data), .pop_i(rd_en_i),
    .data_o(rd_data_o), .empty_o(rx_empty_o), .full_o(rx_full), .count_o(rx_count));

  assign irq_o = int'(rx_count) >= trig_level(trig_sel_i);

  // R5
  tx_full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && tx_full_o && !tx_pop) |=> tx_count == $past(tx_count));
  // R7
  irq_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_empty_o |-> !irq_o);
  // R8
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_store && rx_full && !stat_rd_i) |=> overrun_o);
  // R10
  addr_not_stored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_mode && rx_done && rx_data[8]) |=>
      (rx_count == $past(rx_count)) || $past(rd_en_i));
endmodule

// File: tb/uart_core_bench.sv
module uart_core_bench;
  localparam int BIT = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, stat_rd = 1'b0;
  logic [8:0] wr_data = '0;
  logic       tx_full, rx_empty, overrun, tx, irq;
  logic [8:0] rd_data;
  logic [15:0] prescale = 16'd1;
  logic [3:0] mulval = 4'd1, divadd = 4'd0;
  logic [1:0] trig_sel = 2'd0;
  logic       nine_bit = 1'b0, auto_addr = 1'b0;
  logic [7:0] station = 8'h5A;
  logic       rx = 1'b1, cts = 1'b1;

  int n_vec = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_core u_uart_core (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .tx_full_o(tx_full), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .rx_empty_o(rx_empty), .stat_rd_i(stat_rd), .overrun_o(overrun),
    .prescale_i(prescale), .mulval_i(mulval), .divadd_i(divadd),
    .trig_sel_i(trig_sel), .nine_bit_i(nine_bit), .auto_addr_i(auto_addr),
    .station_addr_i(station), .tx_o(tx), .rx_i(rx), .cts_i(cts), .irq_o(irq));

  // {store expected, frame}; auto address mode, station 0x5A (R10)
  localparam logic [9:0] AUTO_VEC [9] = '{
    {1'b0, 9'h011}, {1'b0, 9'h133}, {1'b0, 9'h15A}, {1'b1, 9'h022},
    {1'b1, 9'h05A}, {1'b0, 9'h134}, {1'b0, 9'h044}, {1'b0, 9'h15A},
    {1'b1, 9'h099}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic write(input logic [8:0] d);
    wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pop();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rx_send(input logic [8:0] frame, input int nbits, input logic stop_v);
    rx = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      rx = frame[i];
      repeat (BIT) @(negedge clk);
    end
    rx = stop_v;
    repeat (BIT) @(negedge clk);
    rx = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic tx_capture(input int nbits, output logic [8:0] frame, output logic stop_v);
    frame = '0;
    while (tx !== 1'b0) @(negedge clk);
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      repeat (BIT) @(negedge clk);
      frame[i] = tx;
    end
    repeat (BIT) @(negedge clk);
    stop_v = tx;
  endtask

  task automatic measure_gap(output int gap);
    int t0;
    while (tx !== 1'b0) @(negedge clk);
    t0 = cyc;
    while (tx !== 1'b1) @(negedge clk);
    while (tx !== 1'b0) @(negedge clk);
    gap = cyc - t0;
  endtask

  task automatic quiet_cycles(input int n, output int lows);
    lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tx !== 1'b1) lows++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [8:0] fr;
    logic       sb;
    int         lows, gap, bad;

    @(negedge clk);
    do_reset();

    // R1 reset state
    chk("R1 tx_o", tx, 1);
    chk("R1 rx_empty", rx_empty, 1);
    chk("R1 tx_full", tx_full, 0);
    chk("R1 irq", irq, 0);
    chk("R1 overrun", overrun, 0);

    // R2 8-bit transmit
    write(9'h0A5);
    tx_capture(8, fr, sb);
    chk("R2 8-bit data", fr, 9'h0A5);
    chk("R2 stop bit", sb, 1);

    // R9 8-bit receive, bit 8 reads 0
    rx_send(9'h1A5, 8, 1'b1);
    chk("R9 8-bit rx", rd_data, 9'h0A5);
    pop();

    // R2 9-bit transmit
    nine_bit = 1'b1;
    repeat (20) @(negedge clk);
    write(9'h1A5);
    tx_capture(9, fr, sb);
    chk("R2 9-bit data", fr, 9'h1A5);
    chk("R2 9-bit stop", sb, 1);

    // R9 9-bit software mode keeps the ninth bit
    rx_send(9'h1C3, 9, 1'b1);
    chk("R9 9-bit addr stored", rd_data, 9'h1C3);
    pop();
    rx_send(9'h042, 9, 1'b1);
    chk("R9 9-bit data stored", rd_data, 9'h042);
    pop();

    // R10 vector table in automatic address mode
    auto_addr = 1'b1;
    foreach (AUTO_VEC[i]) begin
      rx_send(AUTO_VEC[i][8:0], 9, 1'b1);
      if (AUTO_VEC[i][9]) begin
        chk("R10 stored frame", {rx_empty, rd_data}, {1'b0, AUTO_VEC[i][8:0]});
        pop();
      end else begin
        chk("R10 dropped frame", rx_empty, 1);
      end
    end
    auto_addr = 1'b0;
    nine_bit  = 1'b0;

    // R6 short low pulse is not a start bit
    rx = 1'b0;
    repeat (4) @(negedge clk);
    rx = 1'b1;
    repeat (300) @(negedge clk);
    chk("R6 glitch rejected", rx_empty, 1);

    // R11 framing error then recovery
    rx_send(9'h0FF, 8, 1'b0);
    repeat (40) @(negedge clk);
    chk("R11 bad stop dropped", rx_empty, 1);
    rx_send(9'h03C, 8, 1'b1);
    chk("R11 recovery", {rx_empty, rd_data}, {1'b0, 9'h03C});
    pop();

    // R7 thresholds
    trig_sel = 2'd1;
    for (int i = 1; i <= 3; i++) rx_send(9'(i), 8, 1'b1);
    chk("R7 3 below 4", irq, 0);
    rx_send(9'h004, 8, 1'b1);
    chk("R7 4 reaches 4", irq, 1);
    trig_sel = 2'd2; @(negedge clk);
    chk("R7 4 below 8", irq, 0);
    trig_sel = 2'd3; @(negedge clk);
    chk("R7 4 below 14", irq, 0);
    trig_sel = 2'd0; @(negedge clk);
    chk("R7 4 reaches 1", irq, 1);
    for (int i = 0; i < 4; i++) pop();

    // R8 overrun
    trig_sel = 2'd3;
    for (int i = 0; i < 13; i++) rx_send(9'(8'h10 + i), 8, 1'b1);
    chk("R7 13 below 14", irq, 0);
    rx_send(9'h01D, 8, 1'b1);
    chk("R7 14 reaches 14", irq, 1);
    rx_send(9'h01E, 8, 1'b1);
    rx_send(9'h01F, 8, 1'b1);
    chk("R8 no overrun at 16", overrun, 0);
    rx_send(9'h0EE, 8, 1'b1);
    chk("R8 overrun set", overrun, 1);
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    chk("R8 overrun cleared", overrun, 0);
    bad = 0;
    for (int i = 0; i < 16; i++) begin
      if (rd_data !== 9'(8'h10 + i)) bad++;
      pop();
    end
    chk("R8 stored frames kept", bad, 0);
    chk("R8 dropped frame absent", rx_empty, 1);
    trig_sel = 2'd0;

    // R4 CTS low blocks a new frame; R5 full flag
    cts = 1'b0;
    repeat (4) @(negedge clk);
    write(9'h03C);
    quiet_cycles(100, lows);
    chk("R4 no start while cts low", lows, 0);
    for (int i = 0; i < 14; i++) write(9'h055);
    chk("R5 15 entries not full", tx_full, 0);
    write(9'h055);
    chk("R5 16 entries full", tx_full, 1);
    do_reset();

    // R4 frame in progress completes after cts drops
    cts = 1'b1;
    repeat (4) @(negedge clk);
    write(9'h0A5);
    write(9'h05A);
    fork
      tx_capture(8, fr, sb);
      begin
        while (tx !== 1'b0) @(negedge clk);
        repeat (40) @(negedge clk);
        cts = 1'b0;
      end
    join
    chk("R4 frame completes", {sb, fr}, {1'b1, 9'h0A5});
    quiet_cycles(200, lows);
    chk("R4 next frame held", lows, 0);
    cts = 1'b1;
    tx_capture(8, fr, sb);
    chk("R4 resumes after cts", fr, 9'h05A);

    // R3 baud period: integer 1, integer 3, fractional 2 + 1/2
    repeat (40) @(negedge clk);
    write(9'h0FF); write(9'h0FF);
    measure_gap(gap);
    chk("R3 prescale 1 spacing", gap, 160);
    prescale = 16'd3;
    do_reset();
    write(9'h0FF); write(9'h0FF);
    measure_gap(gap);
    chk("R3 prescale 3 spacing", gap, 480);
    prescale = 16'd2; mulval = 4'd2; divadd = 4'd1;
    do_reset();
    write(9'h0FF); write(9'h0FF);
    measure_gap(gap);
    chk("R3 fractional spacing near 400", (gap >= 399 && gap <= 401), 1);
    if (gap < 399 || gap > 401) $display("  measured gap %0d", gap);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule